// File: doc/BRIEF.md
# Component Video Output Conditioner

This block sits between a color-space matrix and the output pins of a video decoder. It takes three 10-bit channels (a luma or green primary channel and two secondary channels) and applies a fixed chain of optional corrections: chroma blanking driven by luma, an inverted chroma sign bit, rounding to 8 significant bits, and substitution of an auxiliary data word into the luma or green path. In the luma/chroma (YC) format it also forces the third channel to zero.

A two-bit format code tells the block what the channels carry, so that chroma-only operations are skipped for RGB and the auxiliary word lands in the right path. All three outputs are registered, and every result appears exactly one clock after its inputs.

Top module: `video_out_cond`

## Requirements
- R1: A synchronous active-high reset drives all three outputs to 0 on the next rising clock edge.
- R2: Outputs are registered with one cycle of latency. With format RGB (code 0) and the balance, invert, round and insert controls all off, each output equals the matching input from the previous cycle.
- R3: With the balance control high and a format that carries chroma (YUV code 1, YCbCr code 2 or YC code 3), a primary-channel value at or below 64 or at or above 940 forces both secondary channels to 0 for that sample. The values 65 and 939 are not at the limit.
- R4: With the balance control low, the secondary channels are not changed by the primary-channel value.
- R5: With the invert control high and a chroma-carrying format, bit 9 of both secondary channels is inverted. Inversion follows blanking, so a blanked sample leaves as 512.
- R6: With the round control high, every channel value v becomes ((v+2) with its two low bits cleared), saturated at 1020. Rounding follows blanking and inversion.
- R7: With insert enable and the insert strobe both high, the auxiliary word replaces the primary channel (green in RGB, luma in YUV and YC) unchanged by rounding. In YCbCr format, or with the strobe low, no insertion takes place.
- R8: In YC format (code 3) the third output is 0 whatever the invert and round controls are.
- R9: In RGB format the balance and invert controls have no effect on any channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pri_in | input | 10 | Primary channel in (green or luma) |
| sec_in | input | 10 | Second channel in (blue, U or Cb, chroma in YC) |
| ter_in | input | 10 | Third channel in (red, V or Cr) |
| fmt_sel | input | 2 | Format: 0 RGB, 1 YUV, 2 YCbCr, 3 YC |
| bal_en | input | 1 | Blank chroma when luma is at a limit |
| inv_en | input | 1 | Invert chroma bit 9 |
| rnd_en | input | 1 | Round all channels to 8 significant bits |
| ins_en | input | 1 | Enable auxiliary word insertion |
| ins_vld | input | 1 | Auxiliary word slot strobe |
| ins_word | input | 10 | Auxiliary data word |
| pri_out | output | 10 | Registered primary channel |
| sec_out | output | 10 | Registered second channel |
| ter_out | output | 10 | Registered third channel |

## Verification
The primary channel is swept across all 1024 codes with balance on and then off, which separates the exact limit thresholds (64/65 and 939/940) from an off-by-one comparison and shows that chroma is untouched when balance is off. Rounding is swept over every code on all three channels at once, distinguishing the half-up carry from truncation and the 1020 saturation from wrap-around. Invert and blanking are combined so that a blanked sample must come out as 512, which fixes the order of the two steps, and insertion is tried in every format with the strobe both high and low together with rounding, which shows the word bypasses rounding and is refused in YCbCr. A final sweep over every control combination in every format catches interactions between the stages.

// File: rtl/vo_pkg.sv
package vo_pkg;
  typedef enum logic [1:0] {
    FMT_RGB = 2'd0,
    FMT_YUV = 2'd1,
    FMT_YCC = 2'd2,
    FMT_YC  = 2'd3
  } vo_fmt_e;

  function automatic logic fmt_has_chroma(vo_fmt_e f);
    return f != FMT_RGB;
  endfunction

  function automatic logic fmt_takes_aux(vo_fmt_e f);
    return f != FMT_YCC;
  endfunction
endpackage

// File: rtl/vo_luma_limit.sv
module vo_luma_limit #(
  parameter int W  = 10,
  parameter int LO = 64,
  parameter int HI = 940
) (
  input  logic [W-1:0] luma,
  output logic         at_limit
);
  localparam logic [W-1:0] LO_V = W'(LO);
  localparam logic [W-1:0] HI_V = W'(HI);

  always_comb begin
    at_limit = (luma <= LO_V) || (luma >= HI_V);
  end
endmodule

// File: rtl/vo_chroma_stage.sv
module vo_chroma_stage #(
  parameter int W = 10
) (
  input  logic [W-1:0] din,
  input  logic         blank,
  input  logic         flip,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] SIGN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] zeroed;

  always_comb begin
    zeroed = blank ? '0 : din;
    dout   = flip ? (zeroed ^ SIGN) : zeroed;
  end
endmodule

// File: rtl/vo_round.sv
module vo_round #(
  parameter int W    = 10,
  parameter int DROP = 2
) (
  input  logic [W-1:0] din,
  input  logic         en,
  output logic [W-1:0] dout
);
  localparam int            HALF  = 1 << (DROP - 1);
  localparam logic [W-1:0]  LOWM  = W'((1 << DROP) - 1);
  localparam logic [W-1:0]  MAXV  = {W{1'b1}} & ~LOWM;

  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, din} + (W+1)'(HALF);
    if (!en)
      dout = din;
    else if (sum > {1'b0, MAXV})
      dout = MAXV;
    else
      dout = sum[W-1:0] & ~LOWM;
  end
endmodule

// File: rtl/video_out_cond.sv
module video_out_cond #(
  parameter int W       = 10,
  parameter int DROP    = 2,
  parameter int LUMA_LO = 64,
  parameter int LUMA_HI = 940
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [9:0]   pri_in,
  input  logic [9:0]   sec_in,
  input  logic [9:0]   ter_in,
  input  logic [1:0]   fmt_sel,
  input  logic         bal_en,
  input  logic         inv_en,
  input  logic         rnd_en,
  input  logic         ins_en,
  input  logic         ins_vld,
  input  logic [9:0]   ins_word,
  output logic [9:0]   pri_out,
  output logic [9:0]   sec_out,
  output logic [9:0]   ter_out
);
  import vo_pkg::*;

  localparam int NCH = 3;

  vo_fmt_e      fmt;
  logic         at_lim;
  logic         do_blank;
  logic         do_flip;
  logic [W-1:0] stage_in  [NCH];
  logic [W-1:0] stage_mid [NCH];
  logic [W-1:0] stage_rnd [NCH];
  logic [W-1:0] nxt_pri, nxt_sec, nxt_ter;

  always_comb begin
    fmt         = vo_fmt_e'(fmt_sel);
    stage_in[0] = pri_in;
    stage_in[1] = sec_in;
    stage_in[2] = ter_in;
    do_blank    = bal_en && fmt_has_chroma(fmt) && at_lim;
    do_flip     = inv_en && fmt_has_chroma(fmt);
  end

  vo_luma_limit #(.W(W), .LO(LUMA_LO), .HI(LUMA_HI)) u_lim (
    .luma     (pri_in),
    .at_limit (at_lim)
  );

  assign stage_mid[0] = stage_in[0];

  genvar gi;
  generate
    for (gi = 1; gi < NCH; gi++) begin : g_chroma
      vo_chroma_stage #(.W(W)) u_cs (
        .din   (stage_in[gi]),
        .blank (do_blank),
        .flip  (do_flip),
        .dout  (stage_mid[gi])
      );
    end
    for (gi = 0; gi < NCH; gi++) begin : g_round
      vo_round #(.W(W), .DROP(DROP)) u_rd (
        .din  (stage_mid[gi]),
        .en   (rnd_en),
        .dout (stage_rnd[gi])
      );
    end
  endgenerate

  always_comb begin
    nxt_pri = stage_rnd[0];
    nxt_sec = stage_rnd[1];
    nxt_ter = stage_rnd[2];
    if (ins_en && ins_vld && fmt_takes_aux(fmt))
      nxt_pri = ins_word;
    if (fmt == FMT_YC)
      nxt_ter = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_out <= '0;
      sec_out <= '0;
      ter_out <= '0;
    end else begin
      pri_out <= nxt_pri;
      sec_out <= nxt_sec;
      ter_out <= nxt_ter;
    end
  end
endmodule

// File: rtl/video_out_cond_chk.sv
module video_out_cond_chk #(
  parameter int W       = 10,
  parameter int DROP    = 2,
  parameter int LUMA_LO = 64,
  parameter int LUMA_HI = 940
) (
  input logic         clk,
  input logic         rst,
  input logic [9:0]   pri_in,
  input logic [9:0]   sec_in,
  input logic [9:0]   ter_in,
  input logic [1:0]   fmt_sel,
  input logic         bal_en,
  input logic         inv_en,
  input logic         rnd_en,
  input logic         ins_en,
  input logic         ins_vld,
  input logic [9:0]   ins_word,
  input logic [9:0]   pri_out,
  input logic [9:0]   sec_out,
  input logic [9:0]   ter_out
);
  logic lim_now;
  assign lim_now = (pri_in <= 10'(LUMA_LO)) || (pri_in >= 10'(LUMA_HI));

  assert_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (fmt_sel == 2'd0 && !rnd_en && !(ins_en && ins_vld))
    |=> (pri_out == $past(pri_in) && sec_out == $past(sec_in) && ter_out == $past(ter_in)));

  assert_blank_R3: assert property (@(posedge clk) disable iff (rst)
    (fmt_sel != 2'd0 && bal_en && lim_now)
    |=> (sec_out == {$past(inv_en), 9'd0}));

  assert_keep_R4: assert property (@(posedge clk) disable iff (rst)
    (fmt_sel == 2'd1 && !bal_en && !inv_en && !rnd_en)
    |=> (sec_out == $past(sec_in) && ter_out == $past(ter_in)));

  assert_round_R6: assert property (@(posedge clk) disable iff (rst)
    rnd_en |=> (sec_out[DROP-1:0] == '0 && ter_out[DROP-1:0] == '0));

  assert_insert_R7: assert property (@(posedge clk) disable iff (rst)
    (ins_en && ins_vld && fmt_sel != 2'd2) |=> (pri_out == $past(ins_word)));

  assert_yc_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (fmt_sel == 2'd3) |=> (ter_out == '0));

  assert_rgb_chroma_R9: assert property (@(posedge clk) disable iff (rst)
    (fmt_sel == 2'd0 && !rnd_en) |=> (sec_out == $past(sec_in)));
endmodule

bind video_out_cond video_out_cond_chk #(
  .W(W), .DROP(DROP), .LUMA_LO(LUMA_LO), .LUMA_HI(LUMA_HI)
) u_chk (
  .clk(clk), .rst(rst), .pri_in(pri_in), .sec_in(sec_in), .ter_in(ter_in),
  .fmt_sel(fmt_sel), .bal_en(bal_en), .inv_en(inv_en), .rnd_en(rnd_en),
  .ins_en(ins_en), .ins_vld(ins_vld), .ins_word(ins_word),
  .pri_out(pri_out), .sec_out(sec_out), .ter_out(ter_out)
);

// File: tb/video_out_cond_test.sv
module video_out_cond_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] pri_in = '0, sec_in = '0, ter_in = '0, ins_word = '0;
  logic [1:0] fmt_sel = '0;
  logic       bal_en = 0, inv_en = 0, rnd_en = 0, ins_en = 0, ins_vld = 0;
  logic [9:0] pri_out, sec_out, ter_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic        pend = 0;
  logic [29:0] exp_q;
  string       tag_q;

  always #4 clk = ~clk;

  video_out_cond uut (
    .clk(clk), .rst(rst), .pri_in(pri_in), .sec_in(sec_in), .ter_in(ter_in),
    .fmt_sel(fmt_sel), .bal_en(bal_en), .inv_en(inv_en), .rnd_en(rnd_en),
    .ins_en(ins_en), .ins_vld(ins_vld), .ins_word(ins_word),
    .pri_out(pri_out), .sec_out(sec_out), .ter_out(ter_out)
  );

  function automatic int rnd8(int v);
    if (v + 2 > 1020) return 1020;
    return ((v + 2) / 4) * 4;
  endfunction

  function automatic logic [29:0] model(int a, int b, int c, int f,
                                         bit bl, bit iv, bit rn, bit ie, bit vl, int w);
    int o0 = a, o1 = b, o2 = c;
    bit lim = (a <= 64) || (a >= 940);
    if (bl && f != 0 && lim) begin o1 = 0; o2 = 0; end
    if (iv && f != 0) begin o1 = o1 ^ 512; o2 = o2 ^ 512; end
    if (rn) begin o0 = rnd8(o0); o1 = rnd8(o1); o2 = rnd8(o2); end
    if (ie && vl && f != 2) o0 = w;
    if (f == 3) o2 = 0;
    return {10'(o0), 10'(o1), 10'(o2)};
  endfunction

  task automatic cmp1(string tag, string ch, logic [9:0] act, logic [9:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, ch, act, exp);
    end
  endtask

  task automatic check_pend();
    if (pend) begin
      cmp1(tag_q, "pri_out", pri_out, exp_q[29:20]);
      cmp1(tag_q, "sec_out", sec_out, exp_q[19:10]);
      cmp1(tag_q, "ter_out", ter_out, exp_q[9:0]);
    end
  endtask

  task automatic drive(int a, int b, int c, int f, bit bl, bit iv, bit rn,
                       bit ie, bit vl, int w, string tag);
    @(negedge clk);
    check_pend();
    pri_in = 10'(a); sec_in = 10'(b); ter_in = 10'(c); fmt_sel = 2'(f);
    bal_en = bl; inv_en = iv; rnd_en = rn; ins_en = ie; ins_vld = vl; ins_word = 10'(w);
    exp_q = model(a & 1023, b & 1023, c & 1023, f, bl, iv, rn, ie, vl, w & 1023);
    tag_q = tag;
    pend = 1;
  endtask

  task automatic flush();
    @(negedge clk);
    check_pend();
    pend = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int lv[8];
    lv = '{0, 63, 64, 65, 500, 939, 940, 1023};

    // R1: reset with busy inputs
    pri_in = 10'd777; sec_in = 10'd333; ter_in = 10'd999; ins_en = 1; ins_vld = 1; ins_word = 10'd5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp1("R1", "pri_out", pri_out, 10'd0);
    cmp1("R1", "sec_out", sec_out, 10'd0);
    cmp1("R1", "ter_out", ter_out, 10'd0);
    rst = 0;

    // R2: RGB pass-through, one-cycle latency
    for (int i = 0; i < 64; i++)
      drive((i*37+11) & 1023, (i*91+5) & 1023, (i*13+700) & 1023, 0, 0, 0, 0, 0, 0, 0, "R2");
    flush();

    // R3: balance on, full luma sweep in YUV
    for (int i = 0; i < 1024; i++)
      drive(i, 300 + (i & 63), 700 - (i & 63), 1, 1, 0, 0, 0, 0, 0, "R3");
    for (int f = 2; f < 4; f++)
      for (int k = 0; k < 8; k++)
        drive(lv[k], 401, 622, f, 1, 0, 0, 0, 0, 0, "R3");
    flush();

    // R4: balance off, chroma untouched
    for (int i = 0; i < 1024; i++)
      drive(i, (i*7+3) & 1023, (i*11+9) & 1023, 1, 0, 0, 0, 0, 0, 0, "R4");
    flush();

    // R5: invert, with and without blanking
    for (int f = 1; f < 4; f++)
      for (int k = 0; k < 8; k++)
        for (int b = 0; b < 2; b++)
          drive(lv[k], 100 + k*97, 900 - k*71, f, b[0], 1, 0, 0, 0, 0, "R5");
    flush();

    // R6: rounding on every code, all channels
    for (int i = 0; i < 1024; i++)
      drive(i, 1023 - i, i ^ 341, 0, 0, 0, 1, 0, 0, 0, "R6");
    for (int i = 0; i < 64; i++)
      drive(100 + i, i*16, 1023 - i*16, 1, 1, 1, 1, 0, 0, 0, "R6");
    flush();

    // R7: insertion in each format, strobe high and low
    for (int f = 0; f < 4; f++)
      for (int m = 0; m < 4; m++)
        for (int k = 0; k < 8; k++)
          drive(200 + k*50, 333, 555, f, 0, 0, k[0], m[0], m[1], 1 + k*127, "R7");
    flush();

    // R8: YC third channel zero
    for (int k = 0; k < 8; k++)
      for (int m = 0; m < 4; m++)
        drive(lv[k], 250 + k, 1023 - k, 3, 0, m[0], m[1], 0, 0, 0, "R8");
    flush();

    // R9: RGB ignores balance and invert
    for (int k = 0; k < 8; k++)
      for (int m = 1; m < 4; m++)
        drive(lv[k], 511 + k, 513 - k, 0, m[0], m[1], 0, 0, 0, 0, "R9");
    flush();

    // All control combinations in all formats
    for (int c = 0; c < 128; c++)
      for (int k = 0; k < 8; k++)
        drive(lv[k], (c*29 + k*131) & 1023, (c*53 + k*17 + 512) & 1023, c & 3,
              c[2], c[3], c[4], c[5], c[6], (c*7 + k) & 1023, "MIX R3 R5 R6 R7 R8");
    flush();

    // R1: reset in mid-stream
    drive(900, 800, 700, 1, 0, 0, 0, 0, 0, 0, "R2");
    flush();
    rst = 1;
    @(negedge clk);
    cmp1("R1", "pri_out", pri_out, 10'd0);
    cmp1("R1", "sec_out", sec_out, 10'd0);
    cmp1("R1", "ter_out", ter_out, 10'd0);
    rst = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule